// File: doc/BRIEF.md
# DPSK Differential Demodulator and Descrambler

This block sits behind the despreading correlators of a direct-sequence receiver. Once per symbol a strobe presents the in-phase and quadrature correlation peaks. The block keeps the previous symbol as a reference and forms the product of the current symbol with the conjugate of that reference. It turns the signs of that product into one data bit per symbol (differential binary PSK) or two bits per symbol (differential quaternary PSK). A single configuration input chooses between the two modes, and the data travels only in the phase change between symbols.

The decoded bits pass through a self-synchronising descrambler built on x^7 + x^4 + 1. They leave as a serial stream, one bit per clock, qualified by a valid strobe. Alongside the data path, the block measures a phase-error magnitude for every decision and smooths it with a first-order recursive average. It compares that average against a programmable threshold to raise a signal-quality warning.

Top module: `dpsk_symbol_demod`

## Requirements
- R1: While reset is asserted and immediately after it: rx_valid is 0, err_avg is 0, err_high is 0 for any threshold, the descrambler history is all zeros and no reference symbol is held.
- R2: The first symbol strobe after reset only stores the reference. It produces no rx_valid pulse and leaves err_avg unchanged.
- R3: With mode_dqpsk = 0, each later strobe yields one bit. The bit is 1 exactly when Re(cur·conj(prev)) = cur_i·prev_i + cur_q·prev_q is negative; zero counts as non-negative.
- R4: With mode_dqpsk = 1, each later strobe yields two bits. The first bit is 1 when Im = cur_q·prev_i − cur_i·prev_q is negative, and the second bit is 1 when Re is negative. This is a Gray mapping: a phase step of 45° gives 00, 135° gives 01, 225° gives 11 and 315° gives 10, written first bit then second bit.
- R5: For a strobe sampled at clock edge E, the first bit is on rx_bit with rx_valid high after edge E+2, for one cycle. In the two-bit mode the second bit follows in the very next cycle. Strobes are at least two cycles apart.
- R6: Each output bit equals the decoded bit XOR the decoded bits 4 and 7 positions earlier in the serial stream. The history is shared by both modes and is zero after reset.
- R7: The per-decision error metric is |Im| in the one-bit mode and ||Re| − |Im|| in the two-bit mode.
- R8: err_avg updates to avg + floor((e − avg)/16) after edge E+2, in the same cycle as the first data bit. At all other times it holds its value.
- R9: err_high is 1 exactly when err_avg is strictly greater than qual_thr, and it follows a threshold change without a clock edge.
- R10: The mode is sampled with each strobe. A mode change keeps the stored reference, so the first symbol after the change is still decided against the last symbol before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sym_stb | input | 1 | One-cycle strobe marking a valid correlator sample |
| mode_dqpsk | input | 1 | 0: one bit per symbol, 1: two bits per symbol |
| sym_i | input | SAMPLE_W | Signed in-phase correlation peak |
| sym_q | input | SAMPLE_W | Signed quadrature correlation peak |
| qual_thr | input | 2*SAMPLE_W | Quality threshold on the averaged error |
| rx_valid | output | 1 | Serial data valid |
| rx_bit | output | 1 | Descrambled serial data bit |
| err_avg | output | 2*SAMPLE_W | Averaged phase-error magnitude |
| err_high | output | 1 | Averaged error above threshold |

## Verification
A strobe driven before edge E leaves rx_valid low after E+1. The first bit and the new average are due after E+2. The second bit in the two-bit mode, or silence in the one-bit mode, is due after E+3. The output is quiet again after E+4.

The bench drives each strobe on a falling edge and samples on the following falling edges. It checks each of those four cycles against a model of the arithmetic, descrambler and average that it keeps itself. The threshold flag is checked shortly after qual_thr changes, with no clock edge in between.

// File: rtl/dpskd_pkg.sv
package dpskd_pkg;

   typedef enum logic {
      MODE_BIT1 = 1'b0,
      MODE_BIT2 = 1'b1
   } dpsk_mode_e;

   typedef struct packed {
      logic two;   // two bits carried by this decision
      logic b0;    // bit emitted first
      logic b1;    // bit emitted second (two-bit mode only)
   } dpsk_dec_t;

endpackage

// File: rtl/dpskd_phase_diff.sv
module dpskd_phase_diff
   import dpskd_pkg::*;
#(
   parameter int SAMPLE_W = 6,
   parameter int ERR_W    = 2 * SAMPLE_W
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       sym_stb,
   input  dpsk_mode_e                 mode,
   input  logic signed [SAMPLE_W-1:0] cur_i,
   input  logic signed [SAMPLE_W-1:0] cur_q,
   output logic                       dec_vld,
   output dpsk_dec_t                  dec,
   output logic [ERR_W-1:0]           dec_err
);
   localparam int PROD_W = ERR_W + 1;

   logic signed [SAMPLE_W-1:0] ref_i, ref_q;
   logic                       have_ref;

   logic signed [PROD_W-1:0] ci_x, cq_x, pi_x, pq_x;
   logic signed [PROD_W-1:0] re_w, im_w;
   logic                     re_neg, im_neg;
   logic [ERR_W-1:0]         re_mag, im_mag, err_nx;
   dpsk_dec_t                dec_nx;

   // conjugate product: cur * conj(ref)
   always_comb begin
      ci_x   = PROD_W'(cur_i);
      cq_x   = PROD_W'(cur_q);
      pi_x   = PROD_W'(ref_i);
      pq_x   = PROD_W'(ref_q);
      re_w   = ci_x * pi_x + cq_x * pq_x;
      im_w   = cq_x * pi_x - ci_x * pq_x;
      re_neg = re_w[PROD_W-1];
      im_neg = im_w[PROD_W-1];
      re_mag = re_neg ? ERR_W'(-re_w) : ERR_W'(re_w);
      im_mag = im_neg ? ERR_W'(-im_w) : ERR_W'(im_w);
   end

   // decision and error metric per mode
   always_comb begin
      dec_nx = '0;
      err_nx = '0;
      case (mode)
         MODE_BIT1: begin
            dec_nx.two = 1'b0;
            dec_nx.b0  = re_neg;
            dec_nx.b1  = 1'b0;
            err_nx     = im_mag;
         end
         MODE_BIT2: begin
            dec_nx.two = 1'b1;
            dec_nx.b0  = im_neg;
            dec_nx.b1  = re_neg;
            err_nx     = (re_mag >= im_mag) ? (re_mag - im_mag) : (im_mag - re_mag);
         end
         default: begin
            dec_nx = '0;
            err_nx = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_i    <= '0;
         ref_q    <= '0;
         have_ref <= 1'b0;
         dec_vld  <= 1'b0;
         dec      <= '0;
         dec_err  <= '0;
      end else begin
         dec_vld <= sym_stb & have_ref;
         if (sym_stb) begin
            ref_i    <= cur_i;
            ref_q    <= cur_q;
            have_ref <= 1'b1;
            dec      <= dec_nx;
            dec_err  <= err_nx;
         end
      end
   end

endmodule

// File: rtl/dpskd_serial.sv
module dpskd_serial
   import dpskd_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      dec_vld,
   input  dpsk_dec_t dec,
   output logic      bit_vld,
   output logic      bit_val
);
   logic pend_q, pend_bit_q;

   // first bit passes straight through, second waits one cycle
   assign bit_vld = dec_vld | pend_q;
   assign bit_val = dec_vld ? dec.b0 : pend_bit_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q     <= 1'b0;
         pend_bit_q <= 1'b0;
      end else begin
         pend_q     <= dec_vld & dec.two;
         pend_bit_q <= dec.b1;
      end
   end

endmodule

// File: rtl/dpskd_descram.sv
module dpskd_descram #(
   parameter int SCR_LEN = 7,
   parameter int SCR_TAP = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_vld,
   input  logic in_bit,
   output logic out_vld,
   output logic out_bit
);
   logic [SCR_LEN-1:0] hist_q, hist_nx;
   logic               clear_bit;

   // history shifts in the received (scrambled) bit
   assign hist_nx[0] = in_bit;
   for (genvar k = 1; k < SCR_LEN; k++) begin : g_shift
      assign hist_nx[k] = hist_q[k-1];
   end

   assign clear_bit = in_bit ^ hist_q[SCR_TAP-1] ^ hist_q[SCR_LEN-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q  <= '0;
         out_vld <= 1'b0;
         out_bit <= 1'b0;
      end else begin
         out_vld <= in_vld;
         if (in_vld) begin
            hist_q  <= hist_nx;
            out_bit <= clear_bit;
         end
      end
   end

endmodule

// File: rtl/dpskd_quality.sv
module dpskd_quality #(
   parameter int ERR_W     = 12,
   parameter int AVG_SHIFT = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dec_vld,
   input  logic [ERR_W-1:0] dec_err,
   input  logic [ERR_W-1:0] thr,
   output logic [ERR_W-1:0] avg,
   output logic             over
);
   logic signed [ERR_W:0]  diff;
   logic        [ERR_W-1:0] step;

   always_comb begin
      diff = $signed({1'b0, dec_err}) - $signed({1'b0, avg});
      step = ERR_W'(diff >>> AVG_SHIFT);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       avg <= '0;
      else if (dec_vld) avg <= avg + step;
   end

   assign over = (avg > thr);

endmodule

// File: rtl/dpsk_symbol_demod.sv
module dpsk_symbol_demod
   import dpskd_pkg::*;
#(
   parameter int SAMPLE_W  = 6,
   parameter int AVG_SHIFT = 4,
   parameter int SCR_LEN   = 7,
   parameter int SCR_TAP   = 4,
   localparam int ERR_W    = 2 * SAMPLE_W
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       sym_stb,
   input  logic                       mode_dqpsk,
   input  logic signed [SAMPLE_W-1:0] sym_i,
   input  logic signed [SAMPLE_W-1:0] sym_q,
   input  logic [ERR_W-1:0]           qual_thr,
   output logic                       rx_valid,
   output logic                       rx_bit,
   output logic [ERR_W-1:0]           err_avg,
   output logic                       err_high
);
   if (SAMPLE_W < 2) begin : g_bad_width
      $error("SAMPLE_W must be at least 2");
   end
   if (SCR_TAP < 1 || SCR_TAP >= SCR_LEN) begin : g_bad_tap
      $error("SCR_TAP must lie between 1 and SCR_LEN-1");
   end
   if (AVG_SHIFT < 1 || AVG_SHIFT >= ERR_W) begin : g_bad_shift
      $error("AVG_SHIFT must lie between 1 and ERR_W-1");
   end

   logic             dec_vld;
   dpsk_dec_t        dec;
   logic [ERR_W-1:0] dec_err;
   logic             ser_vld, ser_bit;

   dpskd_phase_diff #(.SAMPLE_W(SAMPLE_W), .ERR_W(ERR_W)) u_diff (
      .clk     (clk),
      .rst_n   (rst_n),
      .sym_stb (sym_stb),
      .mode    (dpsk_mode_e'(mode_dqpsk)),
      .cur_i   (sym_i),
      .cur_q   (sym_q),
      .dec_vld (dec_vld),
      .dec     (dec),
      .dec_err (dec_err)
   );

   dpskd_serial u_ser (
      .clk     (clk),
      .rst_n   (rst_n),
      .dec_vld (dec_vld),
      .dec     (dec),
      .bit_vld (ser_vld),
      .bit_val (ser_bit)
   );

   dpskd_descram #(.SCR_LEN(SCR_LEN), .SCR_TAP(SCR_TAP)) u_dscr (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_vld  (ser_vld),
      .in_bit  (ser_bit),
      .out_vld (rx_valid),
      .out_bit (rx_bit)
   );

   dpskd_quality #(.ERR_W(ERR_W), .AVG_SHIFT(AVG_SHIFT)) u_qual (
      .clk     (clk),
      .rst_n   (rst_n),
      .dec_vld (dec_vld),
      .dec_err (dec_err),
      .thr     (qual_thr),
      .avg     (err_avg),
      .over    (err_high)
   );

endmodule

// File: rtl/dpskd_chk.sv
module dpskd_chk #(
   parameter int ERR_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sym_stb,
   input logic             dec_vld,
   input logic             dec_two,
   input logic [ERR_W-1:0] dec_err,
   input logic             rx_valid,
   input logic [ERR_W-1:0] err_avg
);
   // R5: strobes must be spaced at least two cycles
   a_r5_stb_gap: assert property (@(posedge clk) disable iff (!rst_n)
      sym_stb |=> !sym_stb);

   // R2: a decision only ever follows a strobe
   a_r2_dec_after_stb: assert property (@(posedge clk) disable iff (!rst_n)
      dec_vld |-> $past(sym_stb));

   // R5: a new run of output bits starts right after a decision
   a_r5_out_after_dec: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_valid) |-> $past(dec_vld));

   // R5: one-bit decisions leave a single valid cycle
   a_r5_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_vld && !dec_two) |=> ##1 !rx_valid);

   // R8: average holds when no decision arrives
   a_r8_avg_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_vld |=> $stable(err_avg));

   // R8: average never moves away from the new sample
   a_r8_avg_up: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_vld && dec_err >= err_avg) |=> err_avg >= $past(err_avg));

   a_r8_avg_down: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_vld && dec_err <= err_avg) |=> err_avg <= $past(err_avg));

endmodule

bind dpsk_symbol_demod dpskd_chk #(.ERR_W(ERR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sym_stb  (sym_stb),
   .dec_vld  (dec_vld),
   .dec_two  (dec.two),
   .dec_err  (dec_err),
   .rx_valid (rx_valid),
   .err_avg  (err_avg)
);

// File: tb/sim_dpsk_symbol_demod.sv
`timescale 1ns/1ps
module sim_dpsk_symbol_demod;
   localparam int SW = 6;
   localparam int EW = 2 * SW;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              sym_stb = 1'b0;
   logic              mode_dqpsk = 1'b0;
   logic signed [SW-1:0] sym_i = '0;
   logic signed [SW-1:0] sym_q = '0;
   logic [EW-1:0]     qual_thr = '0;
   logic              rx_valid, rx_bit, err_high;
   logic [EW-1:0]     err_avg;

   dpsk_symbol_demod u0 (
      .clk(clk), .rst_n(rst_n), .sym_stb(sym_stb), .mode_dqpsk(mode_dqpsk),
      .sym_i(sym_i), .sym_q(sym_q), .qual_thr(qual_thr),
      .rx_valid(rx_valid), .rx_bit(rx_bit), .err_avg(err_avg), .err_high(err_high)
   );

   always #4 clk = ~clk;

   int   n_chk = 0, n_err = 0;
   int   ref_i = 0, ref_q = 0;
   bit   have_ref = 0;
   bit [6:0] sh = '0;
   int   avg = 0;
   int   thr_v = 0;
   bit   just_switched = 0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int iabs(input int v);
      return (v < 0) ? -v : v;
   endfunction

   function automatic bit descr(input bit d);
      bit o;
      o  = d ^ sh[3] ^ sh[6];
      sh = {sh[5:0], d};
      return o;
   endfunction

   task automatic set_thr(input int t);
      thr_v    = t;
      qual_thr = EW'(t);
   endtask

   task automatic send(input int ci, input int cq);
      bit dq, b0, b1, e0, e1;
      int re, im, e;
      dq = mode_dqpsk;
      sym_i = SW'(ci);
      sym_q = SW'(cq);
      sym_stb = 1'b1;
      @(negedge clk);
      sym_stb = 1'b0;
      check(rx_valid == 1'b0, "R5 no output one cycle after strobe", rx_valid, 0);
      @(negedge clk);
      re = ci * ref_i + cq * ref_q;
      im = cq * ref_i - ci * ref_q;
      if (dq) begin
         b0 = (im < 0); b1 = (re < 0); e = iabs(iabs(re) - iabs(im));
      end else begin
         b0 = (re < 0); b1 = 1'b0; e = iabs(im);
      end
      if (have_ref) begin
         e0 = descr(b0);
         check(rx_valid == 1'b1, "R5 first bit valid", rx_valid, 1);
         if (just_switched)
            check(rx_bit == e0, "R10 decision across mode change", rx_bit, e0);
         else if (dq)
            check(rx_bit == e0, "R4 R6 first bit", rx_bit, e0);
         else
            check(rx_bit == e0, "R3 R6 bit", rx_bit, e0);
         avg = avg + ((e - avg) >>> 4);
         check(int'(err_avg) == avg, "R7 R8 averaged error", err_avg, avg);
         check(err_high == (avg > thr_v), "R9 quality flag", err_high, avg > thr_v);
      end else begin
         check(rx_valid == 1'b0, "R2 first symbol silent", rx_valid, 0);
         check(int'(err_avg) == avg, "R2 average untouched", err_avg, avg);
      end
      just_switched = 0;
      @(negedge clk);
      if (have_ref && dq) begin
         e1 = descr(b1);
         check(rx_valid == 1'b1, "R5 second bit valid", rx_valid, 1);
         check(rx_bit == e1, "R4 R6 second bit", rx_bit, e1);
      end else begin
         check(rx_valid == 1'b0, "R5 single bit only", rx_valid, 0);
      end
      check(int'(err_avg) == avg, "R8 average holds", err_avg, avg);
      ref_i = ci;
      ref_q = cq;
      have_ref = 1;
      @(negedge clk);
      check(rx_valid == 1'b0, "R5 output quiet", rx_valid, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      int pv[5];
      pv = '{-32, -7, 0, 9, 31};
      repeat (3) @(negedge clk);
      // R1 reset state
      check(rx_valid == 1'b0, "R1 reset rx_valid", rx_valid, 0);
      check(err_avg == '0, "R1 reset average", err_avg, 0);
      check(err_high == 1'b0, "R1 reset flag", err_high, 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int m = 0; m < 2; m++) begin
         mode_dqpsk = m[0];
         just_switched = (m == 1);
         for (int a = 0; a < 25; a++) begin
            set_thr(a * 90);
            for (int b = 0; b < 25; b++) begin
               send(pv[a / 5], pv[a % 5]);
               send(pv[b / 5], pv[b % 5]);
            end
         end
      end

      // R9 boundary: equality is not "above"
      set_thr(avg);
      #1;
      check(err_high == 1'b0, "R9 threshold equal", err_high, 0);
      if (avg > 0) begin
         set_thr(avg - 1);
         #1;
         check(err_high == 1'b1, "R9 threshold one below", err_high, 1);
      end else begin
         check(err_avg == '0, "R9 average zero", err_avg, 0);
      end
      @(negedge clk);

      // R1 reset in the middle of a stream
      rst_n = 1'b0;
      @(negedge clk);
      check(rx_valid == 1'b0, "R1 mid reset valid", rx_valid, 0);
      check(err_avg == '0, "R1 mid reset average", err_avg, 0);
      rst_n = 1'b1;
      have_ref = 0;
      sh = '0;
      avg = 0;
      set_thr(0);
      @(negedge clk);
      mode_dqpsk = 1'b0;
      send(9, 0);
      send(-7, 0);
      send(31, -32);
      mode_dqpsk = 1'b1;
      just_switched = 1;
      send(0, 9);
      send(-32, -7);
      send(9, 31);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule